// File: doc/BRIEF.md
# Configurable-Depth Pixel Serializer

This block turns a stream of 32-bit memory words into a stream of pixels. It takes words from a show-ahead FIFO: the word is visible whenever the FIFO is not empty, and a one-cycle pop acknowledges it. It sends out one pixel per accepted beat on a valid/ready stream. A pixel can be 1, 2, 4, 8, 16 or 24 bits deep. A 24-bit pixel may start in one word and finish in the next.

Pixels are packed in memory in one of two orders. In the low-first order, the first pixel on screen sits in the least significant bits of a word. In the high-first order, it sits in the most significant bits. The serializer undoes either packing, so pixels always leave in display order. Unused buffered bits are kept between words.

The depth and the order are taken from the configuration inputs only at reset and at a synchronous restart. A restart also throws away every buffered bit and any pixel waiting at the output.

Top module: `pix_serializer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pix_valid` is low. With an empty FIFO, `fifo_pop` stays low.
- R2: `cfg_size` selects the pixel depth. The codes are: 0 gives 1 bit, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16 and 5 gives 24. Codes 6 and 7 behave exactly as code 3 (8 bits).
- R3: When `cfg_big` is 0, the first pixel of the stream is bits [w-1:0] of the first word, where w is the depth. Each following pixel takes the next w higher bits of the bit stream. Word n+1 continues above word n. The pixel is right-aligned on `pix_data`, and every bit at position w or above is zero.
- R4: When `cfg_big` is 1, the first pixel is bits [31:32-w] of the first word. Each following pixel takes the next w lower bits. Word n+1 continues below bit 0 of word n. Bit 31 of the stream is the pixel's most significant bit.
- R5: For depths of 16 bits or less, each word yields exactly 32/w pixels. No bit is dropped or repeated.
- R6: `fifo_pop` is high only when the FIFO is not empty and the buffered bits number fewer than the depth. The word on `fifo_data` is taken in the same cycle. Each popped word is used exactly once.
- R7: For 24-bit pixels, leftover bits carry across word boundaries. Three words give four pixels, and four words give five pixels with 8 bits left buffered.
- R8: While `pix_valid` is high and `pix_ready` is low, `pix_data` and `pix_valid` hold. No pixel is lost or duplicated under any ready pattern.
- R9: Changes on `cfg_size` and `cfg_big` have no effect until a restart. A restart latches them, clears the buffered bits and drops any pending output pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also latches the configuration |
| restart | input | 1 | Synchronous restart: latches the configuration and clears the buffer and the output |
| cfg_size | input | 3 | Pixel depth code |
| cfg_big | input | 1 | 1: first pixel in the high bits of a word; 0: in the low bits |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_data | input | WORD_W | Show-ahead FIFO word |
| fifo_pop | output | 1 | Takes the current FIFO word |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream accepts the pixel |
| pix_data | output | PIX_W | Pixel, right-aligned |

## Verification
The assertions check these rules on every cycle:
- a pop happens only when the FIFO is not empty and the buffer is short of a full pixel;
- the buffered bit count stays within one word plus one pixel;
- a stalled pixel holds steady;
- the bits of `pix_data` above the depth are zero;
- reset and restart clear the output and the buffer.

Only the bench's scenarios can show the following:
- the pixel values come out in display order for both packings and all six depths;
- a 24-bit pixel is stitched correctly from two words;
- the number of pixels per word is right;
- configuration changes in mid-stream are ignored;
- a restart discards leftover bits.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  typedef enum logic [2:0] {
    PXD_1  = 3'd0,
    PXD_2  = 3'd1,
    PXD_4  = 3'd2,
    PXD_8  = 3'd3,
    PXD_16 = 3'd4,
    PXD_24 = 3'd5
  } pxs_depth_e;

  // Depth in bits for a size code; unused codes fall back to 8 bits.
  function automatic logic [5:0] pxs_depth_bits(input logic [2:0] code);
    logic [5:0] w;
    case (pxs_depth_e'(code))
      PXD_1:   w = 6'd1;
      PXD_2:   w = 6'd2;
      PXD_4:   w = 6'd4;
      PXD_8:   w = 6'd8;
      PXD_16:  w = 6'd16;
      PXD_24:  w = 6'd24;
      default: w = 6'd8;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pxs_cfg.sv
module pxs_cfg
  import pxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] size_code,
  input  logic       big_in,
  output logic [5:0] width,
  output logic       big
);

  // The configuration is sampled only at reset or restart (R9).
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      width <= pxs_depth_bits(size_code);
      big   <= big_in;
    end
  end

endmodule

// File: rtl/pxs_unpack.sv
module pxs_unpack #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         restart,
  input  logic [5:0]                   width,
  input  logic                         big,
  input  logic                         fifo_empty,
  input  logic [WORD_W-1:0]            fifo_data,
  input  logic                         take,
  output logic                         fifo_pop,
  output logic                         pix_ok,
  output logic [PIX_W-1:0]             pix_bits,
  output logic [$clog2(2*WORD_W+1)-1:0] cnt
);

  localparam int BUF_W = 2 * WORD_W;
  localparam int CNT_W = $clog2(BUF_W + 1);
  localparam int PAD_W = BUF_W - WORD_W;

  logic [BUF_W-1:0] sr;
  logic [CNT_W-1:0] w_ext;
  logic [PIX_W-1:0] mask;
  logic [PIX_W-1:0] le_pix;
  logic [PIX_W-1:0] be_pix;
  logic [5:0]       be_sh;
  logic [BUF_W-1:0] app;
  logic             emit;

  assign w_ext = CNT_W'(width);

  // One mask bit per pixel bit: keep the bits below the depth.
  for (genvar i = 0; i < PIX_W; i++) begin : g_mask
    assign mask[i] = (6'(i) < width);
  end

  // Low-first: the pixel sits at the bottom of the buffer.
  // High-first: the pixel sits at the top of the buffer.
  assign le_pix = sr[PIX_W-1:0] & mask;
  assign be_sh  = 6'(PIX_W) - width;
  assign be_pix = sr[BUF_W-1 -: PIX_W] >> be_sh;
  assign pix_bits = big ? be_pix : le_pix;

  assign pix_ok   = (cnt >= w_ext);
  assign emit     = pix_ok && take;
  assign fifo_pop = !rst && !restart && !fifo_empty && (cnt < w_ext);

  // A new word goes on just past the valid bits, on the side the order needs.
  assign app = big ? ({fifo_data, {PAD_W{1'b0}}} >> cnt)
                   : ({{PAD_W{1'b0}}, fifo_data} << cnt);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sr  <= '0;
      cnt <= '0;
    end else if (emit) begin
      sr  <= big ? (sr << width) : (sr >> width);
      cnt <= cnt - w_ext;
    end else if (fifo_pop) begin
      sr  <= sr | app;
      cnt <= cnt + CNT_W'(WORD_W);
    end
  end

endmodule

// File: rtl/pxs_out.sv
module pxs_out #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             load,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             ready,
  output logic             take,
  output logic             valid,
  output logic [PIX_W-1:0] data
);

  assign take = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (take) begin
      valid <= load;
      if (load) data <= in_pix;
    end
  end

endmodule

// File: rtl/pix_serializer.sv
module pix_serializer #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [2:0]        cfg_size,
  input  logic              cfg_big,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [PIX_W-1:0]  pix_data
);

  localparam int CNT_W = $clog2(2 * WORD_W + 1);

  logic [5:0]       px_w;
  logic             px_big;
  logic [CNT_W-1:0] buf_cnt;
  logic             pix_ok;
  logic             out_take;
  logic [PIX_W-1:0] pix_next;

  pxs_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .size_code (cfg_size),
    .big_in    (cfg_big),
    .width     (px_w),
    .big       (px_big)
  );

  pxs_unpack #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_unp (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .width      (px_w),
    .big        (px_big),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .take       (out_take),
    .fifo_pop   (fifo_pop),
    .pix_ok     (pix_ok),
    .pix_bits   (pix_next),
    .cnt        (buf_cnt)
  );

  pxs_out #(.PIX_W(PIX_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .load    (pix_ok),
    .in_pix  (pix_next),
    .ready   (pix_ready),
    .take    (out_take),
    .valid   (pix_valid),
    .data    (pix_data)
  );

endmodule

// File: rtl/pxs_chk.sv
module pxs_chk #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24,
  parameter int CNT_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             fifo_empty,
  input logic             fifo_pop,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic [PIX_W-1:0] pix_data,
  input logic [CNT_W-1:0] cnt,
  input logic [5:0]       width
);

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !pix_valid);

  a_r6_pop_needs_word: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  a_r6_pop_only_short: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (cnt < CNT_W'(width)));

  a_r7_buffer_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(width) + CNT_W'(WORD_W));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ((pix_data >> width) == '0));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready && !restart) |=> (pix_valid && $stable(pix_data)));

  a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!pix_valid && cnt == '0));

endmodule

bind pix_serializer pxs_chk #(.WORD_W(WORD_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .restart    (restart),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .pix_data   (pix_data),
  .cnt        (buf_cnt),
  .width      (px_w)
);

// File: tb/pix_serializer_test.sv
`timescale 1ns/1ps
module pix_serializer_test;

  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              restart = 1'b0;
  logic [2:0]        cfg_size = 3'd3;
  logic              cfg_big = 1'b0;
  logic              fifo_empty;
  logic [WORD_W-1:0] fifo_data;
  logic              fifo_pop;
  logic              pix_valid;
  logic              pix_ready = 1'b1;
  logic [PIX_W-1:0]  pix_data;

  always #2.5 clk = ~clk;

  pix_serializer #(.WORD_W(WORD_W), .PIX_W(PIX_W)) uut (
    .clk(clk), .rst(rst), .restart(restart), .cfg_size(cfg_size), .cfg_big(cfg_big),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data)
  );

  int errors = 0;
  int checks = 0;

  // FIFO model (show-ahead)
  logic [31:0] mem [0:15];
  int n_words = 0;
  int idx = 0;
  int pops = 0;
  assign fifo_empty = (idx >= n_words);
  assign fifo_data  = (idx < 16) ? mem[idx] : 32'h0;

  // Captured output pixels
  logic [23:0] cap [0:255];
  int ncap = 0;

  always @(posedge clk) begin
    if (rst || restart) begin
      idx  <= 0;
      pops <= 0;
      ncap <= 0;
    end else begin
      if (fifo_pop) begin
        idx  <= idx + 1;
        pops <= pops + 1;
      end
      if (pix_valid && pix_ready && ncap < 256) begin
        cap[ncap] <= pix_data;
        ncap <= ncap + 1;
      end
    end
  end

  // Ready driver
  bit        stall_mode = 1'b0;
  bit        rdy_force  = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    if (stall_mode) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_ready <= lfsr[0];
    end else begin
      pix_ready <= rdy_force;
    end
  end

  // Watchdog
  int cycles = 0;
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles exp under 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic int depth_of(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 16;
      3'd5: return 24;
      default: return 8;
    endcase
  endfunction

  function automatic logic [23:0] exp_pix(input int k, input int w, input bit big);
    logic [23:0] v = '0;
    for (int b = 0; b < w; b++) begin
      int p  = k * w + b;
      int wi = p / 32;
      int bi = p % 32;
      if (big) v[w-1-b] = mem[wi][31-bi];
      else     v[b]     = mem[wi][bi];
    end
    return v;
  endfunction

  task automatic fill(input int n, input logic [31:0] seed);
    for (int i = 0; i < 16; i++)
      mem[i] = seed ^ (32'(i) * 32'h9E37_79B9) ^ {16'(i), 16'hC35A};
    n_words = n;
  endtask

  task automatic do_restart(input logic [2:0] code, input bit big);
    @(negedge clk);
    cfg_size = code;
    cfg_big  = big;
    restart  = 1'b1;
    @(negedge clk);
    restart  = 1'b0;
    // R9: scramble the configuration inputs; they must be ignored now
    cfg_size = code + 3'd1;
    cfg_big  = ~big;
  endtask

  task automatic run_case(input logic [2:0] code, input bit big, input int n,
                          input bit stall, input logic [31:0] seed, input string req);
    int w;
    int expn;
    w    = depth_of(code);
    expn = (32 * n) / w;
    stall_mode = stall;
    rdy_force  = 1'b1;
    fill(n, seed);
    do_restart(code, big);
    for (int c = 0; c < 4000 && ncap < expn; c++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(ncap == expn, {req, " pixel count"}, ncap, expn);
    chk(pops == n, {req, " R6 words popped"}, pops, n);
    for (int k = 0; k < expn && k < 256; k++)
      chk(cap[k] == exp_pix(k, w, big), {req, " pixel value"}, cap[k], exp_pix(k, w, big));
    stall_mode = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid low in reset", pix_valid, 0);
    chk(fifo_pop == 1'b0, "R1 no pop in reset", fifo_pop, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid low after reset, empty FIFO", pix_valid, 0);
    chk(fifo_pop == 1'b0, "R1 no pop with empty FIFO", fifo_pop, 0);
  endtask

  task automatic t_stall_hold;
    stall_mode = 1'b0;
    rdy_force  = 1'b0;
    fill(2, 32'h1234_5678);
    do_restart(3'd3, 1'b0);
    repeat (10) @(negedge clk);
    chk(pops == 1, "R6 no second pop while buffer holds a pixel", pops, 1);
    chk(pix_valid == 1'b1, "R8 valid held under stall", pix_valid, 1);
    chk(pix_data == 24'(mem[0][7:0]), "R8 data held under stall", pix_data, mem[0][7:0]);
    rdy_force = 1'b1;
    repeat (40) @(negedge clk);
    chk(ncap == 8, "R8 all pixels after stall", ncap, 8);
    for (int k = 0; k < 8; k++)
      chk(cap[k] == exp_pix(k, 8, 1'b0), "R8 pixel after stall", cap[k], exp_pix(k, 8, 1'b0));
  endtask

  initial begin
    fill(0, 32'h0);
    repeat (3) @(negedge clk);
    t_reset();
    run_case(3'd3, 1'b0, 2, 1'b0, 32'hDEAD_BEEF, "R3 low-first 8-bit");
    run_case(3'd3, 1'b1, 2, 1'b0, 32'hDEAD_BEEF, "R4 high-first 8-bit");
    run_case(3'd0, 1'b0, 2, 1'b1, 32'h0F1E_2D3C, "R5 low-first 1-bit stalled");
    run_case(3'd1, 1'b1, 2, 1'b0, 32'h5A5A_C3C3, "R5 high-first 2-bit");
    run_case(3'd2, 1'b0, 3, 1'b1, 32'h7654_3210, "R5 low-first 4-bit stalled");
    run_case(3'd4, 1'b1, 3, 1'b0, 32'hF00D_CAFE, "R5 high-first 16-bit");
    run_case(3'd5, 1'b0, 3, 1'b0, 32'h89AB_CDEF, "R7 low-first 24-bit three words");
    run_case(3'd5, 1'b1, 6, 1'b1, 32'h1357_9BDF, "R7 high-first 24-bit stalled");
    run_case(3'd5, 1'b0, 4, 1'b0, 32'h2468_ACE0, "R7 low-first 24-bit four words");
    run_case(3'd6, 1'b0, 2, 1'b0, 32'hBEEF_0001, "R2 code 6 acts as 8-bit");
    run_case(3'd7, 1'b1, 1, 1'b0, 32'hBEEF_0002, "R2 code 7 acts as 8-bit");
    t_stall_hold();
    run_case(3'd5, 1'b0, 1, 1'b0, 32'hCAFE_0003, "R9 leaves residue");
    run_case(3'd3, 1'b0, 1, 1'b0, 32'hCAFE_0004, "R9 restart discards residue");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule